// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block sequences the serial clock of an I2C master and marks the points where the data line may change or must be sampled. A byte engine above it asks for one phase at a time: a START condition from an idle bus, a single data bit, a repeated START, or a STOP. The generator drives SCL through that phase and pulses `done` when the phase ends. While waiting for the next request it either holds SCL low (parked inside a transfer) or leaves it released (bus idle).

All timing comes from four system-clock counts. The total bit period and the low time are programmed separately, and the high time is their difference. A third count sets the setup and hold around START, repeated START and STOP. A fourth sets how early SDA changes before SCL rises. `sdaChg` pulses in the last cycle before the engine must change SDA, so the engine updates SDA on the edge that ends the pulse. `sdaSample` pulses in the last high cycle of a data bit. If a target stretches the clock by holding SCL low, counting of the high phase waits until the readback shows SCL high.

Top module: `i2c_scl_phase_gen`

## Requirements
- R1: After reset, `sclOut` is 1 (released), `cmdReady` is 1, and `sdaChg`, `sdaSample` and `done` are 0.
- R2: The effective period P is `periodCnt`, or 4 when `periodCnt` is below 4. The effective low count L is `lowCnt`, or floor(P/2) when `lowCnt` is 0 or not below P. The high count is H = P - L.
- R3: A data bit (cmd 1) accepted while parked drives SCL low for L cycles and then releases it for H cycles. `sdaSample` pulses in the last high cycle. In the following cycle SCL is low again and `done` pulses for one cycle.
- R4: During the low phase of a bit, repeated START or STOP, `sdaChg` pulses at low-cycle index L-1-D, counting from 0. D is `setupCnt` clamped to the range 1 to L-1, so D cycles pass between the SDA change and the release of SCL.
- R5: Once SCL is released in a bit, repeated START or STOP, each cycle in which `sclIn` is sampled low extends the high phase by one cycle. Only cycles with `sclIn` high count toward H (for a bit) or S (for a setup).
- R6: A START (cmd 0) is taken only in the idle state. `sdaChg` pulses in the first cycle after acceptance, SCL stays released for S more cycles (S is `holdCnt`, or 1 if it is 0), and then SCL goes low with a `done` pulse.
- R7: A repeated START (cmd 2) runs a low phase of L cycles, then a released setup of S cycles. `sdaChg` pulses in the last of those cycles, and S further released hold cycles follow. SCL then goes low with a `done` pulse.
- R8: A STOP (cmd 3) runs a low phase of L cycles, then a released setup of S cycles with `sdaChg` in its last cycle. The block then goes idle with SCL released, and `done` pulses in the first idle cycle.
- R9: After a STOP, `cmdReady` stays 0 for exactly L cycles starting from the `done` cycle. No START can be accepted during that bus-free time.
- R10: A command illegal in the current state has no effect: a START while parked, or any other command while idle. SCL keeps its level, no strobe or `done` follows, and the block still accepts a legal command afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| periodCnt | input | CW | System clocks per SCL bit |
| lowCnt | input | CW | System clocks SCL is held low per bit |
| holdCnt | input | CW | START/STOP setup and hold clocks |
| setupCnt | input | CW | SDA setup clocks before SCL rises |
| cmdValid | input | 1 | Phase request valid |
| cmd | input | 2 | 0 START, 1 data bit, 2 repeated START, 3 STOP |
| cmdReady | output | 1 | Idle with bus free, or parked with SCL low |
| sclIn | input | 1 | SCL line readback |
| sclOut | output | 1 | 1 releases SCL, 0 pulls it low |
| sdaChg | output | 1 | SDA must change at the end of this cycle |
| sdaSample | output | 1 | Sample SDA in this cycle |
| done | output | 1 | One-cycle pulse when a phase completes |

## Verification
The hardest cases to reach from the ports are a stretched high phase and the bus-free window right after a STOP. The bench models the open-drain line by looping `sclOut` back through a hold-low that it raises on the very cycle it first sees SCL released. The stretch therefore lands exactly on the cycles the high counter must skip, and the bench can check the shift of the sample strobe. For the bus-free window, the bench starts counting cycles with `cmdReady` low from the `done` cycle of the STOP itself, with no idle cycle in between.

// File: rtl/i2c_phase_pkg.sv
package i2c_phase_pkg;

  typedef enum logic [1:0] {
    CMD_START   = 2'd0,
    CMD_BIT     = 2'd1,
    CMD_RESTART = 2'd2,
    CMD_STOP    = 2'd3
  } cmd_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic freeClr;
    logic selHigh;   // 1: high target is H, 0: high target is S
  } dp_ctl_t;

  // datapath -> control compare results
  typedef struct packed {
    logic lowLast;
    logic chgHit;
    logic highLast;
    logic holdLast;
    logic busFree;
  } dp_flag_t;

endpackage

// File: rtl/scl_phase_dp.sv
module scl_phase_dp
  import i2c_phase_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] periodCnt,
  input  logic [CW-1:0] lowCnt,
  input  logic [CW-1:0] holdCnt,
  input  logic [CW-1:0] setupCnt,
  input  dp_ctl_t       ctl,
  output dp_flag_t      flags
);

  localparam logic [CW-1:0] MinPeriod = CW'(4);
  localparam logic [CW-1:0] One       = CW'(1);

  logic [CW-1:0] perEff, lowEff, highEff, holdEff, dsEff, chgPos, highTgt;
  logic [CW-1:0] cnt, freeCnt;

  // clamp the programmed counts to legal values
  always_comb begin
    perEff  = (periodCnt < MinPeriod) ? MinPeriod : periodCnt;
    lowEff  = (lowCnt == '0 || lowCnt >= perEff) ? (perEff >> 1) : lowCnt;
    highEff = perEff - lowEff;
    holdEff = (holdCnt == '0) ? One : holdCnt;
    dsEff   = (setupCnt == '0) ? One : setupCnt;
    chgPos  = (dsEff >= lowEff) ? '0 : (lowEff - One - dsEff);
    highTgt = ctl.selHigh ? highEff : holdEff;
  end

  // shared phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else if (ctl.cntInc) cnt <= cnt + One;
  end

  // bus-free counter, saturates at the low count; all ones means free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 freeCnt <= '1;
    else if (ctl.freeClr)      freeCnt <= '0;
    else if (freeCnt < lowEff) freeCnt <= freeCnt + One;
  end

  always_comb begin
    flags.lowLast  = (cnt == lowEff - One);
    flags.chgHit   = (cnt == chgPos);
    flags.highLast = (cnt == highTgt - One);
    flags.holdLast = (cnt == holdEff - One);
    flags.busFree  = (freeCnt >= lowEff);
  end

  // R2: clamped values always form a legal bit
  a_r2_clamp_legal: assert property (@(posedge clk) disable iff (!rstN)
    (perEff >= MinPeriod) && (lowEff != '0) && (lowEff < perEff));

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import i2c_phase_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  cmd_e     cmd,
  input  logic     sclIn,
  input  dp_flag_t flags,
  output dp_ctl_t  ctl,
  output logic     cmdReady,
  output logic     sclOut,
  output logic     sdaChg,
  output logic     sdaSample,
  output logic     done
);

  typedef enum logic [2:0] {
    S_IDLE, S_MARK, S_HOLD, S_PARK, S_LOW, S_HIGH
  } state_e;

  state_e st, nxt;
  cmd_e   kind, kindNxt;
  logic   doneQ, doneNxt;

  assign cmdReady = (st == S_IDLE && flags.busFree) || (st == S_PARK);

  always_comb begin
    nxt         = st;
    kindNxt     = kind;
    doneNxt     = 1'b0;
    ctl.cntClr  = 1'b0;
    ctl.cntInc  = 1'b0;
    ctl.freeClr = 1'b0;
    ctl.selHigh = (kind == CMD_BIT);
    unique case (st)
      S_IDLE: if (cmdValid && cmdReady && cmd == CMD_START) begin
        nxt        = S_MARK;
        ctl.cntClr = 1'b1;
      end
      S_MARK: nxt = S_HOLD;
      S_HOLD: begin
        ctl.cntInc = 1'b1;
        if (flags.holdLast) begin
          nxt     = S_PARK;
          doneNxt = 1'b1;
        end
      end
      S_PARK: if (cmdValid && cmd != CMD_START) begin
        nxt        = S_LOW;
        kindNxt    = cmd;
        ctl.cntClr = 1'b1;
      end
      S_LOW: begin
        ctl.cntInc = 1'b1;
        if (flags.lowLast) begin
          nxt        = S_HIGH;
          ctl.cntClr = 1'b1;
        end
      end
      S_HIGH: if (sclIn) begin
        ctl.cntInc = 1'b1;
        if (flags.highLast) begin
          unique case (kind)
            CMD_RESTART: begin
              nxt        = S_HOLD;
              ctl.cntClr = 1'b1;
            end
            CMD_STOP: begin
              nxt         = S_IDLE;
              ctl.freeClr = 1'b1;
              doneNxt     = 1'b1;
            end
            default: begin
              nxt     = S_PARK;
              doneNxt = 1'b1;
            end
          endcase
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      kind  <= CMD_BIT;
      doneQ <= 1'b0;
    end else begin
      st    <= nxt;
      kind  <= kindNxt;
      doneQ <= doneNxt;
    end
  end

  assign sclOut    = (st == S_IDLE) || (st == S_MARK) || (st == S_HOLD) || (st == S_HIGH);
  assign sdaChg    = (st == S_MARK) || (st == S_LOW && flags.chgHit) ||
                     (st == S_HIGH && sclIn && flags.highLast && kind != CMD_BIT);
  assign sdaSample = (st == S_HIGH) && sclIn && flags.highLast && (kind == CMD_BIT);
  assign done      = doneQ;

  // R3: done is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3: sampling happens only with SCL released and seen high
  a_r3_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    sdaSample |-> (sclOut && sclIn));
  // R5: a stretched line keeps the block in its high phase
  a_r5_stretch_wait: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_HIGH && !sclIn) |=> (st == S_HIGH && sclOut));
  // R9: first idle cycle after a STOP is never ready
  a_r9_bus_free: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && $past(st) == S_HIGH) |-> !cmdReady);
  // R10: START while parked leaves the block parked
  a_r10_park_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_PARK && cmdValid && cmd == CMD_START) |=> (st == S_PARK && !done));

endmodule

// File: rtl/i2c_scl_phase_gen.sv
module i2c_scl_phase_gen
  import i2c_phase_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] periodCnt,
  input  logic [CW-1:0] lowCnt,
  input  logic [CW-1:0] holdCnt,
  input  logic [CW-1:0] setupCnt,
  input  logic          cmdValid,
  input  logic [1:0]    cmd,
  output logic          cmdReady,
  input  logic          sclIn,
  output logic          sclOut,
  output logic          sdaChg,
  output logic          sdaSample,
  output logic          done
);

  dp_ctl_t  ctl;
  dp_flag_t flags;

  scl_phase_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmd       (cmd_e'(cmd)),
    .sclIn     (sclIn),
    .flags     (flags),
    .ctl       (ctl),
    .cmdReady  (cmdReady),
    .sclOut    (sclOut),
    .sdaChg    (sdaChg),
    .sdaSample (sdaSample),
    .done      (done)
  );

  scl_phase_dp #(.CW(CW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .periodCnt (periodCnt),
    .lowCnt    (lowCnt),
    .holdCnt   (holdCnt),
    .setupCnt  (setupCnt),
    .ctl       (ctl),
    .flags     (flags)
  );

  // R1: released bus is never sampled or strobed together with a change
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(sdaChg && sdaSample));

endmodule

// File: tb/i2c_scl_phase_gen_bench.sv
module i2c_scl_phase_gen_bench;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] periodCnt = '0, lowCnt = '0, holdCnt = '0, setupCnt = '0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmd = 2'd0;
  logic          cmdReady, sclIn, sclOut, sdaChg, sdaSample, done;
  logic          stretch = 1'b0;

  int nChecks = 0, nFail = 0;
  int mLow, mHigh, mChg0, mChg1, mSample, mDone;
  logic mSclAtDone;

  always #10 clk = ~clk;   // 50 MHz

  assign sclIn = sclOut & ~stretch;

  i2c_scl_phase_gen #(.CW(CW)) u_i2c_scl_phase_gen (
    .clk(clk), .rstN(rstN),
    .periodCnt(periodCnt), .lowCnt(lowCnt), .holdCnt(holdCnt), .setupCnt(setupCnt),
    .cmdValid(cmdValid), .cmd(cmd), .cmdReady(cmdReady),
    .sclIn(sclIn), .sclOut(sclOut), .sdaChg(sdaChg), .sdaSample(sdaSample), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int p, input int l, input int s, input int d);
    periodCnt = CW'(p); lowCnt = CW'(l); holdCnt = CW'(s); setupCnt = CW'(d);
  endtask

  // issue one phase and record per-cycle observations until done
  task automatic runCmd(input logic [1:0] c, input int stretchN);
    int rel = 0;
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmd = c;
    @(negedge clk);
    cmdValid = 1'b0;
    mLow = 0; mHigh = 0; mChg0 = -1; mChg1 = -1; mSample = -1; mDone = -1;
    mSclAtDone = 1'bx;
    for (int k = 0; k < 4000; k++) begin
      if (done) begin
        mDone = k; mSclAtDone = sclOut;
        break;
      end
      if (sclOut) mHigh++; else mLow++;
      if (sdaChg) begin
        if (mChg0 < 0) mChg0 = k;
        else if (mChg1 < 0) mChg1 = k;
      end
      if (sdaSample) mSample = k;
      if (sclOut && rel < stretchN) begin stretch = 1'b1; rel++; end
      else stretch = 1'b0;
      @(negedge clk);
    end
    stretch = 1'b0;
  endtask

  // pulse an illegal command and watch that nothing moves
  task automatic illegalCmd(input logic [1:0] c, input string req);
    logic lvl;
    int moves = 0;
    lvl = sclOut;
    cmdValid = 1'b1; cmd = c;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (sclOut != lvl || sdaChg || sdaSample || done) moves++;
      @(negedge clk);
    end
    chk(req, moves, 0);
    chk(req, int'(cmdReady), 1);
  endtask

  task automatic tReset();
    chk("R1 sclOut", int'(sclOut), 1);
    chk("R1 cmdReady", int'(cmdReady), 1);
    chk("R1 strobes", int'(sdaChg) + int'(sdaSample) + int'(done), 0);
  endtask

  task automatic tStart();   // P20 L11 S10 D2
    runCmd(2'd0, 0);
    chk("R6 start chg index", mChg0, 0);
    chk("R6 start high cycles", mHigh, 11);
    chk("R6 start done index", mDone, 11);
    chk("R6 scl low after start", int'(mSclAtDone), 0);
  endtask

  task automatic tBit();
    runCmd(2'd1, 0);
    chk("R3 bit low", mLow, 11);
    chk("R3 bit high", mHigh, 9);
    chk("R4 data change index", mChg0, 8);
    chk("R3 sample index", mSample, 19);
    chk("R3 done index", mDone, 20);
    chk("R3 parked low", int'(mSclAtDone), 0);
  endtask

  task automatic tStretch();
    runCmd(2'd1, 5);
    chk("R5 stretched low", mLow, 11);
    chk("R5 stretched high", mHigh, 14);
    chk("R5 stretched sample", mSample, 24);
  endtask

  task automatic tSetupClamp();
    setupCnt = '0;
    runCmd(2'd1, 0);
    chk("R4 zero setup clamps to 1", mChg0, 9);
    setupCnt = CW'(50);
    runCmd(2'd1, 0);
    chk("R4 large setup clamps to L-1", mChg0, 0);
    setupCnt = CW'(2);
  endtask

  task automatic tRestart();
    runCmd(2'd2, 0);
    chk("R7 restart low", mLow, 11);
    chk("R7 restart high", mHigh, 20);
    chk("R7 data chg", mChg0, 8);
    chk("R7 sda fall index", mChg1, 20);
    chk("R7 done index", mDone, 31);
    chk("R7 parked low", int'(mSclAtDone), 0);
  endtask

  task automatic tStop();
    int n = 0;
    runCmd(2'd3, 0);
    chk("R8 stop low", mLow, 11);
    chk("R8 stop high", mHigh, 10);
    chk("R8 sda rise index", mChg1, 20);
    chk("R8 done index", mDone, 21);
    chk("R8 released", int'(mSclAtDone), 1);
    while (!cmdReady && n < 1000) begin n++; @(negedge clk); end
    chk("R9 bus free cycles", n, 11);
  endtask

  task automatic tClamp();
    setCfg(3, 0, 1, 2);          // P=4 L=2 H=2
    runCmd(2'd0, 0);
    runCmd(2'd1, 0);
    chk("R2 short period low", mLow, 2);
    chk("R2 short period high", mHigh, 2);
    setCfg(10, 10, 1, 2);        // L>=P -> 5/5
    runCmd(2'd1, 0);
    chk("R2 low not below period low", mLow, 5);
    chk("R2 low not below period high", mHigh, 5);
    setCfg(10, 0, 1, 2);         // L=0 -> 5/5
    runCmd(2'd1, 0);
    chk("R2 zero low", mLow, 5);
    runCmd(2'd3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    setCfg(20, 11, 10, 2);
    tStart();
    tBit();
    tStretch();
    tSetupClamp();
    tRestart();
    illegalCmd(2'd0, "R10 start while parked");
    tStop();
    illegalCmd(2'd1, "R10 bit while idle");
    tClamp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule